// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of one burst access in a synchronous DRAM model or controller. A start pulse loads an 8-bit column, a burst length code and an ordering choice (linear or bit-interleaved). From then on the block puts out one column address on every enabled clock until the burst is over.

A fixed burst (1, 2, 4 or 8 beats) ends by itself, and a last-beat flag marks its final address so that the surrounding logic can issue an automatic precharge. A full-page burst steps through all 256 columns, wraps past 255, and runs until a stop request ends it. A new start may arrive in any enabled cycle, even in the middle of a burst, and it restarts the sequence at once. The clock-enable input gates the block with one cycle of delay, which is how a memory device suspends its clock.

Top module: `burst_col_gen`

## Requirements
- R1: During and right after synchronous reset, `col` is 0, and `busy` and `last_beat` are 0.
- R2: A cycle is enabled when `cke` was 1 at the previous rising edge. The reset value of that history bit is 1. When `start` is 1 in an enabled cycle, the next output shows `col` = `start_col` and `busy` = 1.
- R3: With `interleave`=0 and a fixed length N of 2, 4 or 8, beat k has the address (start & ~(N-1)) | ((start + k) mod N). The sequence therefore wraps inside the aligned block of N columns.
- R4: With `interleave`=1 and a fixed length N, beat k has the address start XOR k, where k < N.
- R5: In a full-page burst each enabled cycle adds 1 to `col` modulo 256. The burst passes its start column and keeps going until it is stopped, and `last_beat` stays 0 throughout.
- R6: In a full-page burst, `stop`=1 in an enabled cycle without `start` clears `busy` and leaves `col` unchanged. During a fixed burst or while idle, `stop` has no effect.
- R7: `last_beat` is 1 exactly while `col` shows the final beat of a fixed burst. In the next enabled cycle `busy` and `last_beat` fall to 0, and `col` keeps its last value.
- R8: A `start` during an active burst abandons that burst and begins the new one from its own start column.
- R9: In a cycle that is not enabled, `col`, `busy` and `last_beat` all hold, and `start` and `stop` are ignored.
- R10: Length codes on `blen`: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. The codes 4, 5 and 6 act as 1 beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; takes effect for the following cycle |
| start | input | 1 | Load a new burst |
| start_col | input | 8 | Column where the burst begins |
| blen | input | 3 | Burst length code |
| interleave | input | 1 | 0 = linear order, 1 = interleaved order |
| stop | input | 1 | End a full-page burst |
| col | output | 8 | Current column address |
| busy | output | 1 | A burst is in progress |
| last_beat | output | 1 | `col` is the final beat of a fixed burst |

## Verification
The hardest cases to reach are the ones where enables, stops and restarts fall on the exact beat boundaries. Examples are a `cke` low cycle that lands on the final beat, a stop that arrives together with a start, and a full-page burst that crosses column 255. Random stimulus with a skewed mix of start, stop and enable is used to hit those collisions in many combinations. Directed sequences add a full-page burst that starts near the top of the column range, interleaved bursts that start from unaligned columns, and a start issued in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int COL_W  = 8;
    localparam int BEAT_W = 3;
    localparam logic [2:0] BL_FULL = 3'd7;

    typedef enum logic { ORD_LINEAR = 1'b0, ORD_XOR = 1'b1 } order_e;

    typedef struct packed {
        logic [COL_W-1:0] base;
        logic [2:0]       code;
        order_e           order;
    } burst_cfg_t;

    function automatic logic is_full(input logic [2:0] code);
        return code == BL_FULL;
    endfunction

    // beats minus one, as a low-bit mask
    function automatic logic [BEAT_W-1:0] beat_mask(input logic [2:0] code);
        case (code)
            3'd1:    return BEAT_W'(1);
            3'd2:    return BEAT_W'(3);
            3'd3:    return BEAT_W'(7);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_pkg::*;
(
    input  burst_cfg_t       cfg,
    input  logic [BEAT_W-1:0] beat,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] mask_w;
    logic [COL_W-1:0] lin_low;

    assign mask_w  = COL_W'(beat_mask(cfg.code));
    assign lin_low = cfg.base + COL_W'(beat);

    always_comb begin
        if (cfg.order == ORD_XOR)
            addr = cfg.base ^ (COL_W'(beat) & mask_w);
        else
            addr = (cfg.base & ~mask_w) | (lin_low & mask_w);
    end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic             start,
    input  burst_cfg_t       cfg_in,
    input  logic             stop,
    input  logic [COL_W-1:0] map_addr,
    output burst_cfg_t       cfg_q,
    output logic [BEAT_W-1:0] next_beat,
    output logic [COL_W-1:0] col_q,
    output logic             busy_q,
    output logic             last_q
);
    logic              en_q;
    logic [BEAT_W-1:0] beat_q;
    logic              full_q;

    assign next_beat = beat_q + BEAT_W'(1);
    assign full_q    = is_full(cfg_q.code);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b1;
            cfg_q  <= '0;
            beat_q <= '0;
            col_q  <= '0;
            busy_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            en_q <= cke;
            if (en_q) begin
                if (start) begin
                    cfg_q  <= cfg_in;
                    beat_q <= '0;
                    col_q  <= cfg_in.base;
                    busy_q <= 1'b1;
                    last_q <= !is_full(cfg_in.code) && (beat_mask(cfg_in.code) == '0);
                end else if (busy_q) begin
                    if (full_q) begin
                        if (stop) busy_q <= 1'b0;
                        else      col_q  <= col_q + COL_W'(1);
                    end else if (last_q) begin
                        busy_q <= 1'b0;
                        last_q <= 1'b0;
                    end else begin
                        beat_q <= next_beat;
                        col_q  <= map_addr;
                        last_q <= (next_beat == beat_mask(cfg_q.code));
                    end
                end
            end
        end
    end

    a_r7_last_needs_busy: assert property (@(posedge clk) disable iff (rst)
        last_q |-> busy_q);
    a_r5_full_no_last: assert property (@(posedge clk) disable iff (rst)
        (busy_q && full_q) |-> !last_q);
    a_r9_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> ($stable(col_q) && $stable(busy_q) && $stable(last_q)));
    a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
        (en_q && start) |=> (busy_q && col_q == $past(cfg_in.base)));
    a_r6_stop_ends_full: assert property (@(posedge clk) disable iff (rst)
        (en_q && busy_q && full_q && stop && !start) |=> (!busy_q && $stable(col_q)));
    a_r5_full_step: assert property (@(posedge clk) disable iff (rst)
        (en_q && busy_q && full_q && !stop && !start) |=> (col_q == $past(col_q) + COL_W'(1)));
    a_r7_end_after_last: assert property (@(posedge clk) disable iff (rst)
        (en_q && last_q && !start) |=> !busy_q);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       blen,
    input  logic             interleave,
    input  logic             stop,
    output logic [COL_W-1:0] col,
    output logic             busy,
    output logic             last_beat
);
    burst_cfg_t        cfg_in;
    burst_cfg_t        cfg_q;
    logic [BEAT_W-1:0] next_beat;
    logic [COL_W-1:0]  map_addr;

    assign cfg_in.base  = start_col;
    assign cfg_in.code  = blen;
    assign cfg_in.order = interleave ? ORD_XOR : ORD_LINEAR;

    burst_addr_map u_map (
        .cfg  (cfg_q),
        .beat (next_beat),
        .addr (map_addr)
    );

    burst_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cke       (cke),
        .start     (start),
        .cfg_in    (cfg_in),
        .stop      (stop),
        .map_addr  (map_addr),
        .cfg_q     (cfg_q),
        .next_beat (next_beat),
        .col_q     (col),
        .busy_q    (busy),
        .last_q    (last_beat)
    );
endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1;
    logic       start = 1'b0;
    logic [7:0] start_col = 8'd0;
    logic [2:0] blen = 3'd0;
    logic       interleave = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] col;
    logic       busy;
    logic       last_beat;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    logic       m_en = 1'b1;
    logic       m_busy = 1'b0;
    logic       m_last = 1'b0;
    logic [7:0] m_col = 8'd0;
    logic [7:0] m_base = 8'd0;
    logic [2:0] m_code = 3'd0;
    logic       m_ilv = 1'b0;
    int         m_beat = 0;

    always #4 clk = ~clk;

    burst_col_gen i_burst_col_gen (
        .clk(clk), .rst(rst), .cke(cke), .start(start), .start_col(start_col),
        .blen(blen), .interleave(interleave), .stop(stop),
        .col(col), .busy(busy), .last_beat(last_beat)
    );

    function automatic int blen_beats(input logic [2:0] c);
        case (c)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] beat_addr(input logic [7:0] s, input logic [2:0] c,
                                             input logic ilv, input int k);
        int n;
        int blk;
        n = blen_beats(c);
        if (ilv) return s ^ 8'(k);
        blk = int'(s) - (int'(s) % n);
        return 8'(blk + ((int'(s) + k) % n));
    endfunction

    task automatic check(input string tag, input logic [7:0] a_col, input logic a_busy,
                         input logic a_last);
        n_checks += 3;
        if (a_col !== m_col) begin
            n_fail++;
            $display("FAIL %s col: actual %0d expected %0d", tag, a_col, m_col);
        end
        if (a_busy !== m_busy) begin
            n_fail++;
            $display("FAIL %s busy: actual %0b expected %0b", tag, a_busy, m_busy);
        end
        if (a_last !== m_last) begin
            n_fail++;
            $display("FAIL R7 last_beat (%s): actual %0b expected %0b", tag, a_last, m_last);
        end
    endtask

    task automatic model_edge();
        if (m_en) begin
            if (start) begin
                m_base = start_col; m_code = blen; m_ilv = interleave;
                m_beat = 0; m_col = start_col; m_busy = 1'b1;
                m_last = (blen != 3'd7) && (blen_beats(blen) == 1);
            end else if (m_busy) begin
                if (m_code == 3'd7) begin
                    if (stop) m_busy = 1'b0;
                    else      m_col = m_col + 8'd1;
                end else if (m_last) begin
                    m_busy = 1'b0; m_last = 1'b0;
                end else begin
                    m_beat++;
                    m_col  = beat_addr(m_base, m_code, m_ilv, m_beat);
                    m_last = (m_beat == blen_beats(m_code) - 1);
                end
            end
        end
        m_en = cke;
    endtask

    function automatic string auto_tag();
        if (!m_busy) return "R2";
        if (m_code == 3'd7) return "R5";
        if (m_code > 3'd3) return "R10";
        return m_ilv ? "R4" : "R3";
    endfunction

    task automatic step(input string tag, input logic i_cke, input logic i_start,
                        input logic [7:0] i_col, input logic [2:0] i_len,
                        input logic i_ilv, input logic i_stop);
        cke = i_cke; start = i_start; start_col = i_col; blen = i_len;
        interleave = i_ilv; stop = i_stop;
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        check((tag == "") ? auto_tag() : tag, col, busy, last_beat);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        logic [2:0] codes [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7};
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", col, busy, last_beat);
        rst = 1'b0;
        @(negedge clk);
        check("R1", col, busy, last_beat);

        // R3 linear, length 8, unaligned start 13 -> 13,14,15,8,9,10,11,12
        step("R2", 1, 1, 8'd13, 3'd3, 0, 0);
        for (int i = 0; i < 8; i++) step("R3", 1, 0, 8'd0, 3'd0, 0, 0);
        // R4 interleave, length 8, start 5
        step("R2", 1, 1, 8'd5, 3'd3, 1, 0);
        for (int i = 0; i < 8; i++) step("R4", 1, 0, 8'd0, 3'd0, 0, 1);
        // R5 full page crossing 255, R6 stop
        step("R2", 1, 1, 8'd253, 3'd7, 0, 0);
        for (int i = 0; i < 6; i++) step("R5", 1, 0, 8'd0, 3'd0, 0, 0);
        step("R6", 1, 0, 8'd0, 3'd0, 0, 1);
        step("R6", 1, 0, 8'd0, 3'd0, 0, 0);
        // R6 stop ignored in fixed burst
        step("R2", 1, 1, 8'd2, 3'd2, 0, 0);
        for (int i = 0; i < 5; i++) step("R6", 1, 0, 8'd0, 3'd0, 0, 1);
        // R8 restart mid burst
        step("R2", 1, 1, 8'd40, 3'd3, 0, 0);
        step("R8", 1, 0, 8'd0, 3'd0, 0, 0);
        step("R8", 1, 1, 8'd99, 3'd1, 1, 0);
        step("R8", 1, 0, 8'd0, 3'd0, 0, 0);
        step("R8", 1, 0, 8'd0, 3'd0, 0, 0);
        // R9 cke low holds, start ignored
        step("R2", 1, 1, 8'd60, 3'd7, 0, 0);
        step("R9", 0, 0, 8'd0, 3'd0, 0, 0);
        step("R9", 1, 1, 8'd7, 3'd0, 0, 1);
        step("R9", 1, 0, 8'd0, 3'd0, 0, 0);
        // R10 reserved codes act as single beat
        step("R10", 1, 1, 8'd77, 3'd5, 0, 0);
        step("R10", 1, 0, 8'd0, 3'd0, 0, 0);
        step("R10", 1, 1, 8'd78, 3'd0, 1, 0);
        step("R10", 1, 0, 8'd0, 3'd0, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic r_cke, r_start, r_stop;
            r_cke   = ($urandom % 10) < 8;
            r_start = ($urandom % 100) < 15;
            r_stop  = ($urandom % 100) < 10;
            step("", r_cke, r_start, 8'($urandom), codes[$urandom % 5],
                 1'($urandom), r_stop);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule